// File: doc/BRIEF.md
# Line-at-a-time matrix panel scan driver

This block feeds a matrix panel that shows one row at a time and one bit per pixel. The column side takes pixel bits on several parallel lanes. Each lane feeds its own shift register. Once a full line has been shifted in, a single strobe copies every column bit into a bank of output latches. The panel shows that line while the next one is shifted in behind it.

The row side is a chain of single-bit stages that carries one select token. Each line strobe moves the token to the next row. A frame start that arrives together with a line strobe puts the token back on row 0. After the last row, the token drops off the end and no row is selected until the next frame start. The latch update and the token move happen on the same edge, so the column word a row needs appears in the same cycle that the row becomes selected.

All timing comes from three enable inputs in one clock domain: `shift_en` acts as the pixel clock, `line_strobe` as the line clock and `frame_start` as the frame pulse. Level shifting and analog output stages belong to the panel.

Top module: `panel_scan_drv`

## Requirements
- R1: A synchronous active-low reset clears all row selects and all latched column bits by the next clock edge.
- R2: Column c is carried on lane c mod N_LANES. Within a line, the k-th shifted pixel (k counted from 0) on each lane becomes column N_LANES*k + lane. After LANE_DEPTH shifts and one line strobe, `col_bits[c]` equals that pixel.
- R3: In a cycle with `shift_en` low, `lane_data` is ignored and the shift contents do not change.
- R4: `col_bits` changes only on the edge after `line_strobe` is high, and then holds until the next strobe.
- R5: When `shift_en` and `line_strobe` are high in the same cycle, the latches take the shift contents from before that cycle's shift.
- R6: `line_strobe` with `frame_start` selects only row 0 (`row_sel` bit 0) on the next edge, and discards any token already present.
- R7: `line_strobe` without `frame_start` moves the token from row r to row r+1. A token on the last row leaves no row selected.
- R8: At most one bit of `row_sel` is high at any time.
- R9: `frame_start` without `line_strobe` has no effect on the row selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Pixel strobe: shift one bit into every lane |
| lane_data | input | N_LANES | One pixel bit per lane |
| line_strobe | input | 1 | Latch the line and advance the row token |
| frame_start | input | 1 | Restart the token at row 0 on the next line strobe |
| col_bits | output | N_COLS | Latched column levels for the selected row |
| row_sel | output | N_ROWS | One-hot row select, or all zero while blanking |

## Verification
The assertions assume that the enables are clean one-cycle-per-event levels that are sampled at the clock edge. They also assume that a line is fully shifted in before its strobe. Nothing else is required of the inputs: the row properties hold for any pattern of strobes and frame starts. The bench drives every input at the falling edge and always shifts exactly LANE_DEPTH pixels per line, except in the deliberate overlap case. It also starts each frame with a combined strobe and frame start, so the panel-level sequence stays within those assumptions.

// File: rtl/scan_pkg.sv
// Shared helpers for the matrix scan driver.
// Assumes the column count is a multiple of the lane count.
package scan_pkg;

    // Map a lane and shift stage to the column that the pixel drives.
    function automatic int col_of(input int lane, input int stage, input int lanes);
        return stage * lanes + lane;
    endfunction

endpackage

// File: rtl/col_lane.sv
// One column lane: a shift register that takes one bit per shift enable.
// The newest bit enters at the top. After DEPTH shifts, the first bit of
// the line sits at stage 0. Assumes DEPTH >= 2.
module col_lane #(
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [DEPTH-1:0] stages
);

    // Shift toward stage 0 on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stages <= '0;
        else if (shift_en)
            stages <= {din, stages[DEPTH-1:1]};
    end

endmodule

// File: rtl/line_latch.sv
// Output latch bank: reorders the lane stages into column order and holds
// them from one line strobe to the next. Input is lane-major
// (lane i, stage k at bit i*DEPTH+k).
module line_latch #(
    parameter int N_COLS  = 1024,
    parameter int N_LANES = 4,
    localparam int DEPTH  = N_COLS / N_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [N_COLS-1:0] lane_flat,
    output logic [N_COLS-1:0] col_bits
);
    import scan_pkg::*;

    logic [N_COLS-1:0] by_col;

    // Static rewiring from lane order to column order.
    for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
        for (genvar st = 0; st < DEPTH; st++) begin : g_stage
            assign by_col[col_of(ln, st, N_LANES)] = lane_flat[ln*DEPTH + st];
        end
    end

    // Capture the complete line on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col_bits <= '0;
        else if (load)
            col_bits <= by_col;
    end

endmodule

// File: rtl/row_token.sv
// Row select chain: one token that moves one row per line strobe.
// A frame start with the strobe reloads row 0 and clears the rest.
// Assumes N_ROWS >= 2.
module row_token #(
    parameter int N_ROWS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              restart,
    output logic [N_ROWS-1:0] row_sel
);

    // Advance or reload the token on each line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_sel <= '0;
        else if (step) begin
            if (restart)
                row_sel <= {{(N_ROWS-1){1'b0}}, 1'b1};
            else
                row_sel <= {row_sel[N_ROWS-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/panel_scan_drv.sv
// Top of the matrix panel scan driver. It has N_LANES column lanes that
// feed a line latch, plus a row token chain. The latch and the token update
// on the same edge, so the row data and the row select change together.
module panel_scan_drv #(
    parameter int N_ROWS  = 1024,
    parameter int N_COLS  = 1024,
    parameter int N_LANES = 4,
    localparam int LANE_DEPTH = N_COLS / N_LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic [N_LANES-1:0] lane_data,
    input  logic               line_strobe,
    input  logic               frame_start,
    output logic [N_COLS-1:0]  col_bits,
    output logic [N_ROWS-1:0]  row_sel
);

    logic [N_COLS-1:0] lane_flat;

    // One shift register per lane, packed lane-major.
    for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lanes
        col_lane #(.DEPTH(LANE_DEPTH)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .din      (lane_data[ln]),
            .stages   (lane_flat[ln*LANE_DEPTH +: LANE_DEPTH])
        );
    end

    line_latch #(.N_COLS(N_COLS), .N_LANES(N_LANES)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (line_strobe),
        .lane_flat (lane_flat),
        .col_bits  (col_bits)
    );

    row_token #(.N_ROWS(N_ROWS)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (line_strobe),
        .restart (frame_start),
        .row_sel (row_sel)
    );

endmodule

// File: rtl/scan_drv_chk.sv
// Checker for the scan driver's row and latch timing. It is attached to
// the top with bind. It observes ports only.
module scan_drv_chk #(
    parameter int N_ROWS = 1024,
    parameter int N_COLS = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_strobe,
    input logic              frame_start,
    input logic [N_COLS-1:0] col_bits,
    input logic [N_ROWS-1:0] row_sel
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (row_sel == '0 && col_bits == '0));

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe |=> $stable(col_bits));

    assert_restart_row0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && frame_start) |=> (row_sel[0] && $countones(row_sel) == 1));

    assert_token_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !frame_start) |=> (row_sel == {$past(row_sel[N_ROWS-2:0]), 1'b0}));

    assert_one_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));

    assert_frame_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe |=> $stable(row_sel));

endmodule

bind panel_scan_drv scan_drv_chk #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_scan_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_strobe (line_strobe),
    .frame_start (frame_start),
    .col_bits    (col_bits),
    .row_sel     (row_sel)
);

// File: tb/test_panel_scan_drv.sv
`timescale 1ns/1ps
module test_panel_scan_drv;
    localparam int ROWS  = 8;
    localparam int COLS  = 16;
    localparam int LANES = 4;
    localparam int DEP   = COLS / LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             shift_en = 1'b0;
    logic [LANES-1:0] lane_data = '0;
    logic             line_strobe = 1'b0;
    logic             frame_start = 1'b0;
    logic [COLS-1:0]  col_bits;
    logic [ROWS-1:0]  row_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    panel_scan_drv #(.N_ROWS(ROWS), .N_COLS(COLS), .N_LANES(LANES)) i_panel_scan_drv (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .lane_data(lane_data),
        .line_strobe(line_strobe), .frame_start(frame_start),
        .col_bits(col_bits), .row_sel(row_sel)
    );

    // Pixel level for frame f, line r, column c.
    function automatic logic pat(input int f, input int r, input int c);
        int h;
        h = f*13 + r*29 + c*7 + c*c*3;
        return h[1] ^ h[3];
    endfunction

    function automatic logic [COLS-1:0] line_of(input int f, input int r);
        logic [COLS-1:0] v;
        for (int c = 0; c < COLS; c++) v[c] = pat(f, r, c);
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Shift pixels k0..k1 of a line; column N*k+lane goes on lane.
    task automatic shift_range(input logic [COLS-1:0] ln, input int k0, input int k1);
        for (int k = k0; k <= k1; k++) begin
            shift_en = 1'b1;
            for (int i = 0; i < LANES; i++) lane_data[i] = ln[LANES*k + i];
            @(negedge clk);
        end
        shift_en = 1'b0;
        lane_data = '0;
    endtask

    task automatic strobe(input logic fs);
        line_strobe = 1'b1;
        frame_start = fs;
        @(negedge clk);
        line_strobe = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic row_checks(input string req, input int r);
        logic [63:0] e;
        e = (r < ROWS) ? (64'd1 << r) : 64'd0;
        chk(req, 64'(row_sel), e);
        chk("R8 at most one row", 64'($countones(row_sel) <= 1), 64'd1);
    endtask

    initial begin
        logic [COLS-1:0] prev, cur, nxt;
        repeat (3) @(negedge clk);
        chk("R1 rows cleared", 64'(row_sel), 64'd0);
        chk("R1 columns cleared", 64'(col_bits), 64'd0);
        rst_n = 1'b1;
        prev = '0;
        for (int f = 0; f < 3; f++) begin
            for (int r = 0; r < ROWS; r++) begin
                cur = line_of(f, r);
                shift_range(cur, 0, DEP-1);
                chk("R4 latch holds while shifting", 64'(col_bits), 64'(prev));
                if (f == 1 && r == 3) begin
                    // R3: junk on the lanes with shift disabled
                    for (int j = 0; j < 5; j++) begin
                        lane_data = LANES'(j*5 + 3);
                        @(negedge clk);
                    end
                    lane_data = '0;
                end
                if (f == 1 && r == 5) begin
                    frame_start = 1'b1;
                    @(negedge clk);
                    frame_start = 1'b0;
                    row_checks("R9 frame start alone ignored", r-1);
                end
                strobe(r == 0);
                row_checks(r == 0 ? "R6 frame restart" : "R7 token advance", r);
                chk((f == 1 && r == 3) ? "R3 disabled shift ignored" : "R2 lane mapping",
                    64'(col_bits), 64'(cur));
                prev = cur;
            end
            cur = line_of(f, ROWS);
            shift_range(cur, 0, DEP-1);
            strobe(1'b0);
            row_checks("R7 token falls off last row", ROWS);
            chk("R2 blank line data", 64'(col_bits), 64'(cur));
            strobe(1'b0);
            row_checks("R7 blanking stays empty", ROWS);
            chk("R4 relatch unchanged contents", 64'(col_bits), 64'(cur));
            prev = cur;
        end
        // R5: shift and strobe in the same cycle
        cur = line_of(5, 0);
        shift_range(cur, 0, DEP-1);
        strobe(1'b1);
        chk("R2 overlap setup", 64'(col_bits), 64'(cur));
        cur = line_of(5, 1);
        nxt = line_of(5, 2);
        shift_range(cur, 0, DEP-1);
        shift_en = 1'b1;
        line_strobe = 1'b1;
        for (int i = 0; i < LANES; i++) lane_data[i] = nxt[i];
        @(negedge clk);
        shift_en = 1'b0; line_strobe = 1'b0; lane_data = '0;
        chk("R5 latch takes pre-shift contents", 64'(col_bits), 64'(cur));
        row_checks("R7 advance during overlap", 1);
        shift_range(nxt, 1, DEP-1);
        strobe(1'b0);
        chk("R5 overlapped pixel kept", 64'(col_bits), 64'(nxt));
        row_checks("R7 advance after overlap", 2);
        // R6: restart in mid-frame discards the current token
        strobe(1'b1);
        row_checks("R6 mid-frame restart", 0);
        // R1: reset during activity
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-run rows", 64'(row_sel), 64'd0);
        chk("R1 reset mid-run columns", 64'(col_bits), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule